// File: doc/BRIEF.md
# Multi-Converter Ramp Test Pattern Unit

This block serves test mode on a multi-converter sample path. It contains a ramp source and a ramp monitor. The source fills the outgoing bus with a counting pattern. The monitor takes a received bus and confirms that it still carries a clean ramp. One word per converter is carried on each cycle. Each word holds `SPW` samples of `SAMP_W` bits, so the word width is `SPW * SAMP_W`. The default is 2 x 16 = 32 bits per converter, and the largest sample value is 0xFFFF.

The source is enabled by one bit of a test-control word. While that bit is set, every converter carries the same ramp, which counts up by one per sample and returns to zero after all-ones. The monitor does not need to know the starting value. It takes the first valid word of each converter as its seed and from then on expects the ramp to continue. It also checks that all converters carry the same data. Error flags stay set until `err_clr_i` is pulsed. The clear also makes every converter take a new seed.

Top module: `ramp_test_unit`

## Requirements
- R1: Sample j of a word occupies bits [j*SAMP_W +: SAMP_W], and sample 0 is the oldest. In the first word after reset, sample j equals j. Every converter slot of `gen_data_o` (slot c at bits [c*W +: W]) carries the same word.
- R2: The source runs only while `tst_ctl_i[2]` is 1, and the other control bits have no effect. The bit is sampled at a clock edge, and `gen_valid_o` follows it one cycle later. While the source is stopped, its count is held, and it resumes from that count when the bit is set again.
- R3: Each source word starts one above the last sample of the previous word. After 0xFFFF (all ones) the next sample is 0.
- R4: After reset or a clear, the first valid word of a converter seeds that converter's monitor. Any seed value is accepted if the samples inside that word step by one.
- R5: Once a converter is seeded, sample j of each valid word must equal (last sample of the previous valid word + 1 + j) modulo 2^SAMP_W. Otherwise `conv_err_o[c]` goes high one cycle after that word.
- R6: The monitor accepts the roll from all-ones to zero, both between words and inside a word.
- R7: A seeding word whose samples do not step by one inside the word sets that converter's error.
- R8: If any converter word differs from converter 0 in a valid cycle, `mismatch_err_o` goes high one cycle later. This does not depend on seeding.
- R9: Error flags are sticky. A cycle with `err_clr_i` high clears every flag by the next cycle and re-arms seeding. The data presented in that cycle is ignored.
- R10: Cycles with `rx_valid_i` low are ignored, and the expected value is held across them.
- R11: `any_err_o` is high exactly when some per-converter flag or the mismatch flag is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tst_ctl_i | input | CTL_W | Test-control word; bit 2 enables the source |
| gen_data_o | output | NUM_CONV*SPW*SAMP_W | Source ramp, one word per converter |
| gen_valid_o | output | 1 | Source word valid |
| rx_data_i | input | NUM_CONV*SPW*SAMP_W | Received words to monitor |
| rx_valid_i | input | 1 | Received words valid |
| err_clr_i | input | 1 | Clears all error flags and re-arms seeding |
| conv_err_o | output | NUM_CONV | Sticky ramp error per converter |
| mismatch_err_o | output | 1 | Sticky cross-converter mismatch |
| any_err_o | output | 1 | OR of all error flags |

## Verification
Every result of this block is due exactly one clock edge after its cause. The source word reflects the enable bit sampled at the previous edge, and each error flag reflects the received word or clear sampled at the previous edge. The bench drives inputs on the falling edge. It compares outputs on the next falling edge, which is half a cycle after the capturing rising edge, so each check lands on the first cycle in which the result is due. The wrap case runs the source for the full 2^16 count before it checks the words on either side of the roll.

// File: rtl/ramp_pkg.sv
package ramp_pkg;
  localparam int unsigned CTL_W  = 8;
  localparam int unsigned EN_BIT = 2;

  typedef struct packed {
    logic seeded;
    logic err;
  } lane_flags_t;
endpackage

// File: rtl/ramp_gen.sv
module ramp_gen #(
  parameter int unsigned NUM_CONV = 2,
  parameter int unsigned SAMP_W   = 16,
  parameter int unsigned SPW      = 2,
  localparam int unsigned W       = SPW * SAMP_W
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  en_i,
  output logic [NUM_CONV*W-1:0] data_o,
  output logic                  valid_o
);
  logic [SAMP_W-1:0] cnt_q;
  logic [W-1:0]      word_d, word_q;

  always_comb begin
    for (int j = 0; j < SPW; j++) word_d[j*SAMP_W +: SAMP_W] = cnt_q + SAMP_W'(j);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      word_q  <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= en_i;
      if (en_i) begin
        word_q <= word_d;
        cnt_q  <= cnt_q + SAMP_W'(SPW);  // count held while stopped
      end
    end
  end

  for (genvar c = 0; c < NUM_CONV; c++) begin : g_rep
    assign data_o[c*W +: W] = word_q;
  end
endmodule

// File: rtl/ramp_lane_chk.sv
module ramp_lane_chk #(
  parameter int unsigned SAMP_W = 16,
  parameter int unsigned SPW    = 2,
  localparam int unsigned W     = SPW * SAMP_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] word_i,
  input  logic         valid_i,
  input  logic         clr_i,
  output logic         err_o
);
  import ramp_pkg::*;

  lane_flags_t       st_q;
  logic [SAMP_W-1:0] exp_q;
  logic [SAMP_W-1:0] base;
  logic              bad;

  // unseeded: sample 0 is the seed, rest must step from it
  always_comb begin
    base = st_q.seeded ? exp_q : word_i[SAMP_W-1:0];
    bad  = 1'b0;
    for (int j = 0; j < SPW; j++)
      if (word_i[j*SAMP_W +: SAMP_W] != base + SAMP_W'(j)) bad = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= '0;
      exp_q <= '0;
    end else if (clr_i) begin
      st_q  <= '0;
    end else if (valid_i) begin
      st_q.seeded <= 1'b1;
      exp_q       <= word_i[(SPW-1)*SAMP_W +: SAMP_W] + SAMP_W'(1);
      if (bad) st_q.err <= 1'b1;
    end
  end

  assign err_o = st_q.err;
endmodule

// File: rtl/ramp_xconv_chk.sv
module ramp_xconv_chk #(
  parameter int unsigned NUM_CONV = 2,
  parameter int unsigned W        = 32
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NUM_CONV*W-1:0] data_i,
  input  logic                  valid_i,
  input  logic                  clr_i,
  output logic                  err_o
);
  logic diff;

  always_comb begin
    diff = 1'b0;
    for (int c = 1; c < NUM_CONV; c++)
      if (data_i[c*W +: W] != data_i[W-1:0]) diff = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 err_o <= 1'b0;
    else if (clr_i)              err_o <= 1'b0;
    else if (valid_i && diff)    err_o <= 1'b1;
  end
endmodule

// File: rtl/ramp_test_unit.sv
module ramp_test_unit #(
  parameter int unsigned NUM_CONV = 2,
  parameter int unsigned SAMP_W   = 16,
  parameter int unsigned SPW      = 2,
  parameter int unsigned CTL_W    = ramp_pkg::CTL_W,
  localparam int unsigned W       = SPW * SAMP_W
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [CTL_W-1:0]      tst_ctl_i,
  output logic [NUM_CONV*W-1:0] gen_data_o,
  output logic                  gen_valid_o,
  input  logic [NUM_CONV*W-1:0] rx_data_i,
  input  logic                  rx_valid_i,
  input  logic                  err_clr_i,
  output logic [NUM_CONV-1:0]   conv_err_o,
  output logic                  mismatch_err_o,
  output logic                  any_err_o
);
  logic ctl_unused;
  assign ctl_unused = ^(tst_ctl_i & ~(CTL_W'(1) << ramp_pkg::EN_BIT));

  ramp_gen #(.NUM_CONV(NUM_CONV), .SAMP_W(SAMP_W), .SPW(SPW)) u_gen (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (tst_ctl_i[ramp_pkg::EN_BIT]),
    .data_o (gen_data_o),
    .valid_o(gen_valid_o)
  );

  for (genvar c = 0; c < NUM_CONV; c++) begin : g_lane
    ramp_lane_chk #(.SAMP_W(SAMP_W), .SPW(SPW)) u_lane (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .word_i (rx_data_i[c*W +: W]),
      .valid_i(rx_valid_i),
      .clr_i  (err_clr_i),
      .err_o  (conv_err_o[c])
    );
  end

  ramp_xconv_chk #(.NUM_CONV(NUM_CONV), .W(W)) u_xconv (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .data_i (rx_data_i),
    .valid_i(rx_valid_i),
    .clr_i  (err_clr_i),
    .err_o  (mismatch_err_o)
  );

  assign any_err_o = (|conv_err_o) | mismatch_err_o;
endmodule

// File: rtl/ramp_test_unit_sva.sv
module ramp_test_unit_sva #(
  parameter int unsigned NUM_CONV = 2,
  parameter int unsigned SAMP_W   = 16,
  parameter int unsigned SPW      = 2,
  parameter int unsigned CTL_W    = 8,
  localparam int unsigned W       = SPW * SAMP_W
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic [CTL_W-1:0]      tst_ctl_i,
  input logic [NUM_CONV*W-1:0] gen_data_o,
  input logic                  gen_valid_o,
  input logic [NUM_CONV*W-1:0] rx_data_i,
  input logic                  rx_valid_i,
  input logic                  err_clr_i,
  input logic [NUM_CONV-1:0]   conv_err_o,
  input logic                  mismatch_err_o,
  input logic                  any_err_o
);
  function automatic logic steps_ok(input logic [W-1:0] w);
    steps_ok = 1'b1;
    for (int j = 1; j < SPW; j++)
      if (w[j*SAMP_W +: SAMP_W] != w[(j-1)*SAMP_W +: SAMP_W] + SAMP_W'(1)) steps_ok = 1'b0;
  endfunction

  function automatic logic all_same(input logic [NUM_CONV*W-1:0] d);
    all_same = 1'b1;
    for (int c = 1; c < NUM_CONV; c++)
      if (d[c*W +: W] != d[W-1:0]) all_same = 1'b0;
  endfunction

  // R2
  gen_on_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tst_ctl_i[ramp_pkg::EN_BIT] |=> gen_valid_o);

  // R2
  gen_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tst_ctl_i[ramp_pkg::EN_BIT] |=> !gen_valid_o);

  // R1
  gen_same_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gen_valid_o |-> (all_same(gen_data_o) && steps_ok(gen_data_o[W-1:0])));

  // R3
  gen_cont_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gen_valid_o && $past(gen_valid_o)) |->
      gen_data_o[SAMP_W-1:0] == $past(gen_data_o[(SPW-1)*SAMP_W +: SAMP_W]) + SAMP_W'(1));

  // R8
  mismatch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_i && !err_clr_i && !all_same(rx_data_i)) |=> mismatch_err_o);

  // R9
  clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_clr_i |=> (conv_err_o == '0 && !mismatch_err_o));

  // R9
  sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !err_clr_i |=> (((conv_err_o & $past(conv_err_o)) == $past(conv_err_o)) &&
                    (mismatch_err_o || !$past(mismatch_err_o))));

  // R10
  rise_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(any_err_o) |-> $past(rx_valid_i));
endmodule

bind ramp_test_unit ramp_test_unit_sva #(
  .NUM_CONV(NUM_CONV), .SAMP_W(SAMP_W), .SPW(SPW), .CTL_W(CTL_W)
) u_sva (
  .clk_i(clk_i), .rst_ni(rst_ni), .tst_ctl_i(tst_ctl_i),
  .gen_data_o(gen_data_o), .gen_valid_o(gen_valid_o),
  .rx_data_i(rx_data_i), .rx_valid_i(rx_valid_i), .err_clr_i(err_clr_i),
  .conv_err_o(conv_err_o), .mismatch_err_o(mismatch_err_o), .any_err_o(any_err_o)
);

// File: tb/sim_ramp_test_unit.sv
`timescale 1ns/100ps
module sim_ramp_test_unit;
  localparam int NC = 2, SW = 16, SPW = 2, W = SPW*SW;

  logic              clk = 1'b0, rst_n = 1'b0;
  logic [7:0]        tst_ctl = '0;
  logic [NC*W-1:0]   gen_data, rx_data = '0;
  logic              gen_valid, rx_valid = 1'b0, err_clr = 1'b0;
  logic [NC-1:0]     conv_err;
  logic              mism_err, any_err;
  int                n_chk = 0, n_fail = 0;
  logic [SW-1:0]     gen_base = '0;
  bit                done = 0;

  always #2.5 clk = ~clk;

  ramp_test_unit #(.NUM_CONV(NC), .SAMP_W(SW), .SPW(SPW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .tst_ctl_i(tst_ctl),
    .gen_data_o(gen_data), .gen_valid_o(gen_valid),
    .rx_data_i(rx_data), .rx_valid_i(rx_valid), .err_clr_i(err_clr),
    .conv_err_o(conv_err), .mismatch_err_o(mism_err), .any_err_o(any_err));

  function automatic logic [W-1:0] mk(input logic [SW-1:0] b);
    for (int j = 0; j < SPW; j++) mk[j*SW +: SW] = b + SW'(j);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_gen(input string req, input logic [SW-1:0] b);
    logic [NC*W-1:0] e;
    e = {NC{mk(b)}};
    chk(gen_valid && gen_data == e, req, 64'(gen_data), 64'(e));
  endtask

  task automatic chk_err(input string req, input logic [NC-1:0] ce, input logic me);
    chk(conv_err == ce && mism_err == me && any_err == ((|ce) | me), req,
        64'({conv_err, mism_err, any_err}), 64'({ce, me, (|ce) | me}));
  endtask

  task automatic send(input logic [W-1:0] w0, input logic [W-1:0] w1, input logic v);
    rx_data = {w1, w0}; rx_valid = v;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic clear();
    err_clr = 1'b1; @(negedge clk); err_clr = 1'b0;
  endtask

  task automatic t_reset();
    chk(!gen_valid, "R2 reset valid", 64'(gen_valid), 0);
    chk_err("R11 reset flags", '0, 1'b0);
  endtask

  task automatic t_gen_basic();
    tst_ctl = 8'h04;
    @(negedge clk); chk_gen("R1 first word", 16'h0000);
    @(negedge clk); chk_gen("R1 second word", 16'h0002);
    gen_base = 16'h0004;
  endtask

  task automatic t_gen_enable();
    tst_ctl = 8'hFB;  // every bit but the enable
    @(negedge clk); chk(!gen_valid, "R2 stop", 64'(gen_valid), 0);
    @(negedge clk); chk(!gen_valid, "R2 stay stopped", 64'(gen_valid), 0);
    tst_ctl = 8'h04;
    @(negedge clk); chk_gen("R2 resume held count", gen_base);
    gen_base = gen_base + SW'(SPW);
  endtask

  task automatic t_gen_wrap();
    int bad = 0;
    while (gen_base != 16'hFFFE) begin
      @(negedge clk);
      if (!gen_valid || gen_data != {NC{mk(gen_base)}}) bad++;
      gen_base = gen_base + SW'(SPW);
    end
    chk(bad == 0, "R3 long run", 64'(bad), 0);
    @(negedge clk); chk_gen("R3 all-ones word", 16'hFFFE);
    @(negedge clk); chk_gen("R3 wrapped word", 16'h0000);
    tst_ctl = 8'h00;
    @(negedge clk);
  endtask

  task automatic t_seed_run();
    clear();
    send(mk(16'h1234), mk(16'h1234), 1'b1); chk_err("R4 arbitrary seed", '0, 1'b0);
    send(mk(16'h1236), mk(16'h1236), 1'b1); chk_err("R5 continuing word", '0, 1'b0);
    send(mk(16'hBEEF), mk(16'h0101), 1'b0); chk_err("R10 invalid ignored", '0, 1'b0);
    send(mk(16'h1238), mk(16'h1238), 1'b1); chk_err("R10 expectation held", '0, 1'b0);
  endtask

  task automatic t_step_err();
    send(mk(16'h1250), mk(16'h123A), 1'b1);
    chk_err("R5 jump on converter 0 only", 2'b01, 1'b1);
    @(negedge clk); @(negedge clk);
    chk_err("R9 flags sticky", 2'b01, 1'b1);
  endtask

  task automatic t_clear_wrap();
    rx_data = {mk(16'h5555), mk(16'h0AAA)}; rx_valid = 1'b1; err_clr = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0; err_clr = 1'b0;
    chk_err("R9 clear", '0, 1'b0);
    send(mk(16'hFFFE), mk(16'hFFFE), 1'b1); chk_err("R9 data in clear cycle ignored", '0, 1'b0);
    send(mk(16'h0000), mk(16'h0000), 1'b1); chk_err("R6 wrap between words", '0, 1'b0);
    clear();
    send(mk(16'hFFFF), mk(16'hFFFF), 1'b1); chk_err("R6 wrap inside word", '0, 1'b0);
  endtask

  task automatic t_intra();
    clear();
    send({16'h0003, 16'h0005}, mk(16'h0005), 1'b1);
    chk_err("R7 bad step in seed word", 2'b01, 1'b1);
  endtask

  task automatic t_mismatch();
    clear();
    send(mk(16'h0100), mk(16'h0200), 1'b1);
    chk_err("R8 differing converters", '0, 1'b1);
    send(mk(16'h0102), mk(16'h0202), 1'b1);
    chk_err("R8 per-converter ramps still clean", '0, 1'b1);
    clear();
    send(mk(16'h0300), mk(16'h0300), 1'b1);
    send(mk(16'h0302), mk(16'h0399), 1'b1);
    chk_err("R5 only converter 1 flagged", 2'b10, 1'b1);
  endtask

  initial begin
    #(5ns * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_gen_basic();
    t_gen_enable();
    t_gen_wrap();
    t_seed_run();
    t_step_err();
    t_clear_wrap();
    t_intra();
    t_mismatch();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule